// File: doc/BRIEF.md
# Iambic Morse Paddle Keyer

This block converts a two-lever Morse paddle into a correctly timed key line plus an audio sidetone. One lever asks for dits and the other asks for dahs. Holding a single lever repeats its element. Squeezing both levers makes the keyer alternate between the two element types. If the lever for the other element is touched while an element is being sent, the keyer remembers it and sends exactly one of that element next. The operator does not need to tap at any precise moment.

All timing comes from a unit period. A prescaler divides the clock into base ticks. A fractional accumulator then adds the speed setting in words per minute on every base tick and emits a unit tick each time the running sum passes a parameter constant, so the unit period is `UNIT_K / wpm` base ticks. A mode input chooses how a squeeze that is released is finished. In mode B the keyer completes the alternation. In mode A it stops after the element in progress. While the key line is active, a square wave at audio rate is produced for monitoring.

Top module: `iambic_keyer`

## Requirements
- R1: Each paddle input passes through two flip-flops before the keying logic sees it, so a press takes effect no sooner than the third clock edge after it.
- R2: With only the dit paddle held, the keyer sends an unbroken series of dits and stops after the element during which the paddle was released.
- R3: With only the dah paddle held, the keyer sends an unbroken series of dahs.
- R4: With both paddles held, the elements alternate. When both are pressed together from idle, a dit is sent first.
- R5: A dit keys the line for 1 unit and a dah for 3 units. Consecutive elements are separated by exactly 1 unkeyed unit. Every rise and fall of the key line happens on the clock edge that follows a unit tick.
- R6: A press of the opposite paddle at any time during an element, including its trailing gap, causes exactly one opposite element to be sent next.
- R7: With `mode_b` = 1, after a squeeze in which both paddles are released during an element, the keyer still sends the one remembered opposite element.
- R8: With `mode_b` = 0, after a squeeze in which both paddles are released during an element, the keyer sends nothing more once that element ends.
- R9: The unit period is `UNIT_K / wpm` base ticks, where a base tick is `TICK_DIV` clock cycles. The speed input may be changed while idle.
- R10: `sidetone` is low whenever `key_out` is low. It starts low with each element and changes level every `TONE_DIV` clock cycles while the key is held.
- R11: After reset, `key_out` and `sidetone` are low and stay low while no paddle is pressed.
- R12: The remembered opposite-paddle bit is clear on the edge at which a new element begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dit_paddle | input | 1 | Dit lever, high while pressed, asynchronous |
| dah_paddle | input | 1 | Dah lever, high while pressed, asynchronous |
| mode_b | input | 1 | 1 selects mode B squeeze completion, 0 selects mode A |
| wpm | input | WPM_W | Speed in words per minute |
| key_out | output | 1 | Key line, high while an element is keyed |
| sidetone | output | 1 | Audio square wave, gated by the key line |

## Verification
A paddle press reaches the synchronised level after two edges. The element then starts on the edge after the next unit tick, so the delay from press to key rise is between 3 and U+2 cycles, where U is the unit period in clocks. The bench checks that this delay falls within that window and does not demand an exact cycle. From the rise onward, every edge of the key line lies on a unit tick. For that reason the monitor, sampling on the falling clock edge, counts how long each high and low interval lasts instead of checking absolute times. It compares each high interval with the queued expectation of 1 or 3 units, and each gap inside a run with exactly one unit. The first sidetone change is due `TONE_DIV` cycles after the key rises, and each later change `TONE_DIV` cycles after the previous one. The monitor measures those intervals within each element. Paddle releases are driven just after the monitor sees a key fall, which leaves at least two cycles of margin before the next decision tick.

// File: rtl/keyer_pkg.sv
package keyer_pkg;
   typedef enum logic [1:0] {
      KS_IDLE  = 2'd0,
      KS_MARK  = 2'd1,
      KS_SPACE = 2'd2
   } key_state_e;

   localparam int unsigned DIT_UNITS  = 1;
   localparam int unsigned DAH_UNITS  = 3;
   localparam int unsigned GAP_UNITS  = 1;
   localparam int unsigned UCNT_W     = 2;
endpackage

// File: rtl/keyer_sync.sv
module keyer_sync #(
   parameter int unsigned W = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] meta_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         meta_q <= '0;
         q      <= '0;
      end else begin
         meta_q <= d;
         q      <= meta_q;
      end
   end
endmodule

// File: rtl/keyer_timebase.sv
module keyer_timebase #(
   parameter int unsigned TICK_DIV = 2,
   parameter int unsigned UNIT_K   = 60,
   parameter int unsigned WPM_W    = 5
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WPM_W-1:0] wpm,
   output logic             unit_tick
);
   localparam int unsigned PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
   localparam int unsigned ACC_W = $clog2(UNIT_K + (1 << WPM_W)) + 1;

   if (TICK_DIV < 1) begin : g_bad_div
      $error("keyer_timebase: TICK_DIV must be at least 1");
   end
   if (UNIT_K < 1 || ((1 << WPM_W) - 1) > UNIT_K) begin : g_bad_k
      $error("keyer_timebase: UNIT_K must cover the largest wpm value");
   end

   logic base_tick;

   if (TICK_DIV == 1) begin : g_nodiv
      assign base_tick = 1'b1;
   end else begin : g_div
      logic [PRE_W-1:0] pre_q;
      always_ff @(posedge clk) begin
         if (rst)                                  pre_q <= '0;
         else if (pre_q == PRE_W'(TICK_DIV - 1))   pre_q <= '0;
         else                                      pre_q <= pre_q + PRE_W'(1);
      end
      assign base_tick = (pre_q == PRE_W'(TICK_DIV - 1));
   end

   logic [ACC_W-1:0] acc_q;
   logic [ACC_W-1:0] acc_sum;

   assign acc_sum = acc_q + ACC_W'(wpm);

   always_ff @(posedge clk) begin
      if (rst) begin
         acc_q     <= '0;
         unit_tick <= 1'b0;
      end else begin
         unit_tick <= 1'b0;
         if (base_tick) begin
            if (acc_sum >= ACC_W'(UNIT_K)) begin
               acc_q     <= acc_sum - ACC_W'(UNIT_K);
               unit_tick <= 1'b1;
            end else begin
               acc_q <= acc_sum;
            end
         end
      end
   end
endmodule

// File: rtl/keyer_fsm.sv
module keyer_fsm
   import keyer_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic unit_tick,
   input  logic dit,
   input  logic dah,
   input  logic mode_b,
   output logic key,
   output logic opp_mem
);
   key_state_e        state_q;
   logic              cur_dah_q;
   logic              squeeze_q;
   logic [UCNT_W-1:0] cnt_q;

   logic opp_held, use_mem, decide, go, nxt_dah;

   assign opp_held = cur_dah_q ? dit : dah;
   assign use_mem  = opp_mem && !(!mode_b && squeeze_q && !dit && !dah);
   assign decide   = unit_tick &&
                     (state_q == KS_IDLE || (state_q == KS_SPACE && cnt_q == '0));

   always_comb begin
      go      = 1'b0;
      nxt_dah = cur_dah_q;
      if (state_q == KS_IDLE) begin
         if (dit)      begin go = 1'b1; nxt_dah = 1'b0; end
         else if (dah) begin go = 1'b1; nxt_dah = 1'b1; end
      end else begin
         if (use_mem || (dit && dah)) begin go = 1'b1; nxt_dah = ~cur_dah_q; end
         else if (dit)                begin go = 1'b1; nxt_dah = 1'b0; end
         else if (dah)                begin go = 1'b1; nxt_dah = 1'b1; end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q   <= KS_IDLE;
         cur_dah_q <= 1'b0;
         opp_mem   <= 1'b0;
         squeeze_q <= 1'b0;
         cnt_q     <= '0;
      end else if (decide && go) begin
         state_q   <= KS_MARK;
         cur_dah_q <= nxt_dah;
         cnt_q     <= nxt_dah ? UCNT_W'(DAH_UNITS - 1) : UCNT_W'(DIT_UNITS - 1);
         opp_mem   <= 1'b0;
         squeeze_q <= 1'b0;
      end else begin
         if (state_q != KS_IDLE) begin
            if (opp_held)    opp_mem   <= 1'b1;
            if (dit && dah)  squeeze_q <= 1'b1;
         end
         if (unit_tick) begin
            case (state_q)
               KS_MARK: begin
                  if (cnt_q == '0) begin
                     state_q <= KS_SPACE;
                     cnt_q   <= UCNT_W'(GAP_UNITS - 1);
                  end else begin
                     cnt_q <= cnt_q - UCNT_W'(1);
                  end
               end
               KS_SPACE: begin
                  if (cnt_q == '0) begin
                     state_q <= KS_IDLE;
                     opp_mem <= 1'b0;
                  end else begin
                     cnt_q <= cnt_q - UCNT_W'(1);
                  end
               end
               default: state_q <= KS_IDLE;
            endcase
         end
      end
   end

   assign key = (state_q == KS_MARK);
endmodule

// File: rtl/keyer_tone.sv
module keyer_tone #(
   parameter int unsigned TONE_DIV = 3
) (
   input  logic clk,
   input  logic rst,
   input  logic key,
   output logic tone_out
);
   localparam int unsigned TW = (TONE_DIV > 1) ? $clog2(TONE_DIV) : 1;

   if (TONE_DIV < 1) begin : g_bad_tone
      $error("keyer_tone: TONE_DIV must be at least 1");
   end

   logic phase_q;

   if (TONE_DIV == 1) begin : g_fast
      always_ff @(posedge clk) begin
         if (rst || !key) phase_q <= 1'b0;
         else             phase_q <= ~phase_q;
      end
   end else begin : g_div
      logic [TW-1:0] tcnt_q;
      always_ff @(posedge clk) begin
         if (rst || !key) begin
            tcnt_q  <= '0;
            phase_q <= 1'b0;
         end else if (tcnt_q == TW'(TONE_DIV - 1)) begin
            tcnt_q  <= '0;
            phase_q <= ~phase_q;
         end else begin
            tcnt_q <= tcnt_q + TW'(1);
         end
      end
   end

   assign tone_out = key & phase_q;
endmodule

// File: rtl/iambic_keyer.sv
module iambic_keyer #(
   parameter int unsigned CLK_HZ   = 200_000_000,
   parameter int unsigned TICK_DIV = CLK_HZ / 1000,
   parameter int unsigned UNIT_K   = 1200,
   parameter int unsigned WPM_W    = 6,
   parameter int unsigned TONE_HZ  = 700,
   parameter int unsigned TONE_DIV = CLK_HZ / (2 * TONE_HZ)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             dit_paddle,
   input  logic             dah_paddle,
   input  logic             mode_b,
   input  logic [WPM_W-1:0] wpm,
   output logic             key_out,
   output logic             sidetone
);
   logic unit_tick;
   logic dit_s, dah_s;
   logic opp_mem;

   keyer_sync #(.W(2)) u_sync (
      .clk (clk),
      .rst (rst),
      .d   ({dah_paddle, dit_paddle}),
      .q   ({dah_s, dit_s})
   );

   keyer_timebase #(
      .TICK_DIV (TICK_DIV),
      .UNIT_K   (UNIT_K),
      .WPM_W    (WPM_W)
   ) u_tb (
      .clk       (clk),
      .rst       (rst),
      .wpm       (wpm),
      .unit_tick (unit_tick)
   );

   keyer_fsm u_fsm (
      .clk       (clk),
      .rst       (rst),
      .unit_tick (unit_tick),
      .dit       (dit_s),
      .dah       (dah_s),
      .mode_b    (mode_b),
      .key       (key_out),
      .opp_mem   (opp_mem)
   );

   keyer_tone #(.TONE_DIV(TONE_DIV)) u_tone (
      .clk      (clk),
      .rst      (rst),
      .key      (key_out),
      .tone_out (sidetone)
   );
endmodule

// File: rtl/keyer_checker.sv
module keyer_checker (
   input logic clk,
   input logic rst,
   input logic dit_paddle,
   input logic dah_paddle,
   input logic key_out,
   input logic unit_tick,
   input logic dit_s,
   input logic dah_s,
   input logic opp_mem
);
   logic [1:0] warm_q;

   always_ff @(posedge clk) begin
      if (rst)                warm_q <= 2'd0;
      else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
   end

   a_r1_sync_dit: assert property (@(posedge clk) disable iff (rst)
      (warm_q == 2'd2) |-> (dit_s == $past(dit_paddle, 2)));

   a_r1_sync_dah: assert property (@(posedge clk) disable iff (rst)
      (warm_q == 2'd2) |-> (dah_s == $past(dah_paddle, 2)));

   a_r5_rise_on_tick: assert property (@(posedge clk) disable iff (rst)
      $rose(key_out) |-> $past(unit_tick));

   a_r5_fall_on_tick: assert property (@(posedge clk) disable iff (rst)
      $fell(key_out) |-> $past(unit_tick));

   a_r12_mem_clear: assert property (@(posedge clk) disable iff (rst)
      $rose(key_out) |-> !opp_mem);
endmodule

bind iambic_keyer keyer_checker u_chk (
   .clk        (clk),
   .rst        (rst),
   .dit_paddle (dit_paddle),
   .dah_paddle (dah_paddle),
   .key_out    (key_out),
   .unit_tick  (unit_tick),
   .dit_s      (dit_s),
   .dah_s      (dah_s),
   .opp_mem    (opp_mem)
);

// File: tb/tb_iambic_keyer.sv
`timescale 1ns/1ps
module tb_iambic_keyer;
   localparam int TICK_DIV = 2;
   localparam int UNIT_K   = 60;
   localparam int WPM_W    = 5;
   localparam int TONE_DIV = 3;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic dit_paddle = 1'b0;
   logic dah_paddle = 1'b0;
   logic mode_b = 1'b1;
   logic [WPM_W-1:0] wpm = 5'd20;
   logic key_out, sidetone;

   always #2.5 clk = ~clk;

   iambic_keyer #(
      .CLK_HZ(1000), .TICK_DIV(TICK_DIV), .UNIT_K(UNIT_K),
      .WPM_W(WPM_W), .TONE_HZ(1), .TONE_DIV(TONE_DIV)
   ) dut (
      .clk(clk), .rst(rst), .dit_paddle(dit_paddle), .dah_paddle(dah_paddle),
      .mode_b(mode_b), .wpm(wpm), .key_out(key_out), .sidetone(sidetone)
   );

   int n_chk = 0, n_err = 0;
   int exp_q[$];
   int unit_clk = 6;
   int rises = 0, falls = 0;
   bit prev_valid = 0;
   string run_req = "R11";

   task automatic check(bit ok, string req, string what, int act, int expv);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
      end
   endtask

   task automatic push(int units);
      exp_q.push_back(units * unit_clk);
   endtask

   // monitor / scoreboard
   bit key_d = 0, tone_d = 0;
   int hi = 0, lo = 0, last_chg = -1, iv_err = 0, t_rises = 0, quiet_err = 0;

   always @(negedge clk) begin
      if (!rst) begin
         if (key_out) begin
            if (!key_d) begin
               rises++;
               if (prev_valid) check(lo == unit_clk, "R5", "gap inside run", lo, unit_clk);
               hi = 0; last_chg = -1; iv_err = 0; t_rises = 0;
            end
            hi++;
            if (key_d && (sidetone != tone_d)) begin
               if (last_chg >= 0 && (hi - last_chg) != TONE_DIV) iv_err++;
               last_chg = hi;
               if (sidetone) t_rises++;
            end
         end else begin
            if (key_d) begin
               falls++;
               if (exp_q.size() == 0) begin
                  check(1'b0, run_req, "element not expected", hi, 0);
               end else begin
                  int e;
                  e = exp_q.pop_front();
                  check(hi == e, "R5", "element length", hi, e);
               end
               check(t_rises >= 1 && iv_err == 0, "R10", "tone interval errors", iv_err, 0);
               prev_valid = 1;
               lo = 0;
            end
            lo++;
            if (sidetone) quiet_err++;
         end
         key_d  = key_out;
         tone_d = sidetone;
      end
   end

   task automatic tick_n(int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   task automatic wait_falls(int base, int n);
      while (falls < base + n) begin @(negedge clk); #1; end
   endtask

   task automatic wait_rises(int base, int n);
      while (rises < base + n) begin @(negedge clk); #1; end
   endtask

   task automatic end_run(string req);
      while (exp_q.size() != 0) begin @(negedge clk); #1; end
      tick_n(8 * unit_clk);
      check(key_out == 1'b0, req, "idle after run", key_out, 0);
      prev_valid = 0;
   endtask

   task automatic squeeze_run(bit mb, string req);
      int bf;
      mode_b = mb; run_req = req; bf = falls;
      push(1); push(3); push(1); push(3);
      if (mb) push(1);
      dit_paddle = 1; dah_paddle = 1;
      wait_falls(bf, 4);
      dit_paddle = 0; dah_paddle = 0;
      end_run(req);
   endtask

   task automatic insert_run(bit mb);
      int bf, br;
      mode_b = mb; run_req = "R6"; bf = falls; br = rises;
      push(3); push(3); push(1); push(3);
      dah_paddle = 1;
      wait_rises(br, 2);
      dit_paddle = 1; tick_n(3); dit_paddle = 0;
      wait_falls(bf, 4);
      dah_paddle = 0;
      end_run("R6");
   endtask

   // watchdog
   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_chk++; n_err++;
         $display("FAIL %s watchdog: actual=%0d expected<=%0d", run_req, cyc, 150000);
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      int bf, lat;
      tick_n(4);
      check(key_out == 0 && sidetone == 0, "R11", "outputs in reset", {key_out, sidetone}, 0);
      rst = 0;
      tick_n(40);
      check(key_out == 0 && sidetone == 0, "R11", "idle after reset", {key_out, sidetone}, 0);

      // R2 + R1: hold dit, three dits, check press-to-key latency
      run_req = "R2"; bf = falls;
      push(1); push(1); push(1);
      dit_paddle = 1; lat = 0;
      while (!key_out) begin @(negedge clk); #1; lat++; end
      check(lat >= 3 && lat <= unit_clk + 2, "R1", "press to key latency", lat, 3);
      wait_falls(bf, 3);
      dit_paddle = 0;
      end_run("R2");

      // R3: hold dah
      run_req = "R3"; bf = falls;
      push(3); push(3); push(3);
      dah_paddle = 1;
      wait_falls(bf, 3);
      dah_paddle = 0;
      end_run("R3");

      // R4/R7: squeeze, mode B completes the iamb
      squeeze_run(1'b1, "R7");
      // R4/R8: squeeze, mode A stops
      squeeze_run(1'b0, "R8");

      // R6/R12: opposite-paddle insertion, both modes
      insert_run(1'b1);
      insert_run(1'b0);

      // R9: faster speed, unit becomes UNIT_K/30 = 2 base ticks = 4 clocks
      wpm = 5'd30; unit_clk = 4; mode_b = 1;
      tick_n(20);
      run_req = "R9"; bf = falls;
      push(1); push(1);
      dit_paddle = 1;
      wait_falls(bf, 2);
      dit_paddle = 0;
      end_run("R9");
      squeeze_run(1'b1, "R4");

      check(quiet_err == 0, "R10", "sidetone high while key low", quiet_err, 0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule